// File: doc/BRIEF.md
# Byte-Level EEPROM Emulation Backend for an I2C Target

This block is the data side of an I2C target that acts like a small byte-addressed EEPROM. A separate bus engine handles bit timing, address matching and clock stretching. It passes this block three transaction events (write-start, read-start, stop), hands over every byte the controller writes, and asks for every byte the controller reads. The backend holds the memory, an 8-bit address pointer and a flag that marks the next written byte as a pointer load.

After a write-start, the first received byte moves the pointer and is not stored. Every later received byte is stored at the pointer, and the pointer then advances. Each read request returns the byte at the pointer and then advances it. The pointer wraps at the memory size in both directions. A small configuration port programs up to four inclusive address windows and can delete them. When a stored byte lands inside a valid window, the block reports the address and the value on a one-cycle notification strobe. It gives one strobe per matching window, in ascending window order.

Top module: `eeprom_emu_backend`

## Requirements
- R1: After reset the pointer is 0, the pointer-load flag is clear, and every window is invalid. A byte received before any event is therefore stored at address 0, and no notification appears.
- R2: `ev_wr_start` sets the pointer-load flag. `ev_rd_start` and `ev_stop` clear it, and they take priority over `ev_wr_start` in the same cycle. With the flag clear, the next received byte is stored.
- R3: A byte received while the flag is set is loaded into the pointer and is not written to memory. The flag clears in the same cycle.
- R4: A byte received while the flag is clear is stored at the pointer, and the pointer then increments modulo 256, so 255 is followed by 0.
- R5: A `tx_req` pulse that is not accompanied by `rx_valid` gives `tx_valid` high for one cycle on the following cycle, with `tx_data` equal to the byte at the pointer. The pointer then increments modulo 256.
- R6: A store at address A with value V, where A lies in the inclusive range [start, start+len-1] of a valid window i, produces a `note_valid` strobe with `note_idx`=i, `note_addr`=A and `note_data`=V. With several matching windows, one strobe appears per window in consecutive cycles, lowest index first. The first strobe appears in the cycle after the store.
- R7: A `cfg_wr` pulse gives `cfg_done` high in the next cycle. `cfg_err` is set in that same cycle when `cfg_len` is 0 or `cfg_start`+`cfg_len` exceeds 256. A rejected request leaves the window unchanged. An accepted one makes window `cfg_idx` valid with the given range.
- R8: A `cfg_del` pulse (with no `cfg_wr`) invalidates window `cfg_idx` and gives `cfg_done` high with `cfg_err` low in the next cycle.
- R9: Pointer loads, reads, and stores outside every valid window produce no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | Write transaction started |
| ev_rd_start | input | 1 | Read transaction started |
| ev_stop | input | 1 | Transaction ended |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to send |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Byte to send |
| cfg_wr | input | 1 | Program a window |
| cfg_del | input | 1 | Delete a window |
| cfg_idx | input | 2 | Window index |
| cfg_start | input | 8 | Window start address |
| cfg_len | input | 9 | Window length in bytes |
| cfg_done | output | 1 | Configuration request completed |
| cfg_err | output | 1 | Configuration request rejected |
| note_valid | output | 1 | Watched-store notification strobe |
| note_idx | output | 2 | Window that matched |
| note_addr | output | 8 | Address that was stored |
| note_data | output | 8 | Value that was stored |

## Verification
The assertions check on every cycle the local pointer rules: a load after a write-start, an increment after a store or a fetch, the flag's response to the three events, and the one-cycle response on the read and configuration ports. Only the bench's scenarios can show what memory actually holds, where the pointer wraps, and whether window bounds are inclusive. They also show that rejected windows stay unchanged, and that overlapping windows give their strobes in order with the right address and value. Those scenarios are checked against a bench-side model of memory, pointer and windows.

// File: rtl/eeprom_emu_backend.sv
module eeprom_emu_backend #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NWIN = 4,
  localparam int DEPTH = 1 << AW,
  localparam int IW    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_wr_start,
  input  logic          ev_rd_start,
  input  logic          ev_stop,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_req,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          cfg_wr,
  input  logic          cfg_del,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW:0]   cfg_len,
  output logic          cfg_done,
  output logic          cfg_err,
  output logic          note_valid,
  output logic [IW-1:0] note_idx,
  output logic [AW-1:0] note_addr,
  output logic [DW-1:0] note_data
);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   ptr;
  logic            load_next;
  logic [NWIN-1:0] w_ok, hit, pend, grant;
  logic [AW-1:0]   w_lo [NWIN];
  logic [AW-1:0]   w_hi [NWIN];
  logic [AW-1:0]   p_addr [NWIN];
  logic [DW-1:0]   p_data [NWIN];

  wire store = rx_valid && !load_next;
  wire fetch = tx_req && !rx_valid;
  wire [AW+1:0] cfg_sum = {1'b0, cfg_start} + {1'b0, cfg_len};
  wire cfg_bad = (cfg_len == '0) || (cfg_sum > (AW+2)'(DEPTH));
  wire [AW-1:0] cfg_end = AW'(cfg_sum - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      load_next <= 1'b0;
    end else begin
      if (rx_valid)   ptr <= load_next ? AW'(rx_data) : ptr + 1'b1;
      else if (fetch) ptr <= ptr + 1'b1;
      if (ev_stop || ev_rd_start) load_next <= 1'b0;
      else if (ev_wr_start)       load_next <= 1'b1;
      else if (rx_valid)          load_next <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[ptr] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= fetch;
      if (fetch) tx_data <= mem[ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_done <= cfg_wr || cfg_del;
      cfg_err  <= cfg_wr && cfg_bad;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = w_ok[g] && (ptr >= w_lo[g]) && (ptr <= w_hi[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w_ok[g] <= 1'b0;
        w_lo[g] <= '0;
        w_hi[g] <= '0;
      end else if (cfg_wr && cfg_idx == IW'(g)) begin
        if (!cfg_bad) begin
          w_ok[g] <= 1'b1;
          w_lo[g] <= cfg_start;
          w_hi[g] <= cfg_end;
        end
      end else if (cfg_del && cfg_idx == IW'(g)) begin
        w_ok[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g]   <= 1'b0;
        p_addr[g] <= '0;
        p_data[g] <= '0;
      end else if (store && hit[g]) begin
        pend[g]   <= 1'b1;
        p_addr[g] <= ptr;
        p_data[g] <= rx_data;
      end else if (grant[g]) begin
        pend[g] <= 1'b0;
      end
    end
  end

  assign grant      = pend & (~pend + 1'b1);
  assign note_valid = |pend;

  always_comb begin
    note_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (pend[i]) note_idx = IW'(i);
  end

  assign note_addr = p_addr[note_idx];
  assign note_data = p_data[note_idx];

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && load_next |=> ptr == $past(AW'(rx_data)) && !load_next); // R3
  AST_PTR_STORE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !load_next |=> ptr == AW'($past(ptr) + 1'b1)); // R4
  AST_PTR_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !rx_valid |=> tx_valid && ptr == AW'($past(ptr) + 1'b1)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_start && !ev_rd_start && !ev_stop |=> load_next); // R2
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_start || ev_stop |=> !load_next); // R2
  AST_CFG_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr || cfg_del |=> cfg_done); // R7
  AST_DEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_del && !cfg_wr |=> !cfg_err); // R8
  AST_NOTE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !store |=> $countones(pend) == $countones($past(pend)) - 1); // R6

endmodule

// File: tb/eeprom_emu_backend_tb.sv
module eeprom_emu_backend_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_wr_start = 0, ev_rd_start = 0, ev_stop = 0;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic tx_req = 0;
  logic tx_valid;
  logic [7:0] tx_data;
  logic cfg_wr = 0, cfg_del = 0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_start = '0;
  logic [8:0] cfg_len = '0;
  logic cfg_done, cfg_err, note_valid;
  logic [1:0] note_idx;
  logic [7:0] note_addr, note_data;

  always #10 clk = ~clk;

  eeprom_emu_backend u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .cfg_wr(cfg_wr), .cfg_del(cfg_del), .cfg_idx(cfg_idx),
    .cfg_start(cfg_start), .cfg_len(cfg_len),
    .cfg_done(cfg_done), .cfg_err(cfg_err),
    .note_valid(note_valid), .note_idx(note_idx),
    .note_addr(note_addr), .note_data(note_data)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_ptr = '0;
  bit m_load = 0;
  bit m_ok [4];
  int m_lo [4];
  int m_hi [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit in_win(input int i, input int a);
    return m_ok[i] && a >= m_lo[i] && a <= m_hi[i];
  endfunction

  task automatic ev(input int kind);
    if (kind == 0) ev_wr_start = 1;
    else if (kind == 1) ev_rd_start = 1;
    else ev_stop = 1;
    step();
    ev_wr_start = 0; ev_rd_start = 0; ev_stop = 0;
    m_load = (kind == 0);
  endtask

  task automatic do_rx(input logic [7:0] b);
    bit was_load = m_load;
    logic [7:0] a = m_ptr;
    rx_valid = 1; rx_data = b;
    step();
    rx_valid = 0;
    if (was_load) begin
      m_ptr = b; m_load = 0;
    end else begin
      m_mem[a] = b; m_ptr = a + 8'd1;
      for (int i = 0; i < 4; i++) begin
        if (in_win(i, a)) begin
          chk(note_valid && note_idx == 2'(i), "R6", "note index", note_idx, i);
          chk(note_addr == a && note_data == b, "R6", "note addr/data",
              {note_addr, note_data}, {a, b});
          step();
        end
      end
    end
    chk(!note_valid, was_load ? "R3" : "R9", "no further note", note_valid, 0);
  endtask

  task automatic do_tx(input string req);
    tx_req = 1;
    step();
    tx_req = 0;
    chk(tx_valid == 1'b1, "R5", "tx_valid", tx_valid, 1);
    chk(tx_data == m_mem[m_ptr], req, "tx_data", tx_data, m_mem[m_ptr]);
    chk(!note_valid, "R9", "no note on read", note_valid, 0);
    m_ptr = m_ptr + 8'd1;
  endtask

  task automatic do_cfg(input int idx, input int st, input int len);
    bit bad = (len == 0) || (st + len > 256);
    cfg_wr = 1; cfg_idx = 2'(idx); cfg_start = 8'(st); cfg_len = 9'(len);
    step();
    cfg_wr = 0;
    chk(cfg_done == 1'b1, "R7", "cfg_done", cfg_done, 1);
    chk(cfg_err == bad, "R7", "cfg_err", cfg_err, bad);
    if (!bad) begin
      m_ok[idx] = 1; m_lo[idx] = st; m_hi[idx] = st + len - 1;
    end
  endtask

  task automatic do_del(input int idx);
    cfg_del = 1; cfg_idx = 2'(idx);
    step();
    cfg_del = 0;
    chk(cfg_done && !cfg_err, "R8", "delete response", {cfg_done, cfg_err}, 2'b10);
    m_ok[idx] = 0;
  endtask

  task automatic seek(input logic [7:0] a);
    ev(0);
    do_rx(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_ok[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !cfg_done && !note_valid, "R1", "outputs idle after reset",
        {tx_valid, cfg_done, note_valid}, 0);

    // R1: pointer 0 and flag clear, so this byte is stored at address 0
    do_rx(8'hA5);
    seek(8'h00);
    ev(1);
    do_tx("R1");

    // R4: fill all 256 bytes from address 0; pointer wraps back to 0
    seek(8'h00);
    for (int i = 0; i < 256; i++) do_rx(8'(i * 7 + 3));
    do_tx("R4");

    // R2/R3: a stop clears the flag, so the byte after it is stored
    seek(8'h10);
    ev(0);
    ev(2);
    do_rx(8'h77);
    seek(8'h10);
    ev(1);
    do_tx("R2");
    // R3: loaded byte must not be stored: address 0x55 keeps fill value
    seek(8'h55);
    seek(8'h56);
    seek(8'h55);
    do_tx("R3");
    do_tx("R3");

    // R5: read wrap 255 -> 0
    seek(8'hFF);
    ev(1);
    do_tx("R5");
    do_tx("R5");

    // R7: boundary programming
    do_cfg(0, 250, 6);
    do_cfg(1, 250, 7);
    do_cfg(1, 0, 0);
    do_cfg(1, 248, 4);
    do_cfg(2, 251, 1);
    do_cfg(3, 0, 256);
    // R6: store at 251 matches windows 0,1,2,3 in order
    seek(8'd251);
    do_rx(8'hC3);
    do_rx(8'h3C);
    // R8: delete window 3, then an address only it covered gives no note
    do_del(3);
    seek(8'd10);
    do_rx(8'h42);
    // R6: edges of window 0 inclusive: 249 outside 0, 255 inside
    seek(8'd249);
    do_rx(8'h11);
    seek(8'd255);
    do_rx(8'h22);
    do_rx(8'h33);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 10) ev($urandom_range(0, 2));
      else if (r < 55) do_rx(8'($urandom));
      else if (r < 80) do_tx("R5");
      else if (r < 93) do_cfg($urandom_range(0, 3), $urandom_range(0, 255),
                              ($urandom_range(0, 9) == 0) ? $urandom_range(0, 256)
                                                          : $urandom_range(0, 24));
      else do_del($urandom_range(0, 3));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule